// File: doc/BRIEF.md
# Banked Status-Save and Exception-Return Unit

This block keeps one saved copy of the processor status word for each exception mode and, when a handler asks to return, produces the status word and program counter to resume with. At exception entry the core drives the save port with the mode being entered and the status word being preserved, and the unit files the word in that mode's bank. At return the core raises a request with the current mode, the current status word, the current link register value and a return-kind code. One clock later the unit presents the restored status word and program counter together with a valid strobe. If the current mode has no bank, it presents an error strobe instead.

Only the mode field (bits 4:0), T (bit 5), F (bit 6) and I (bit 7) of the status word have fixed places. The unit does not interpret them except for the mode field, and carries all higher bits through untouched. A three-state machine decides the outcome of each request. IDLE is the state with no request in the previous cycle. RESTORE is the state after a request from a banked mode and drives the valid strobe. REFUSE is the state after a request from a mode without a bank and drives the error strobe. From any state the machine moves to RESTORE on a request whose mode has a bank, to REFUSE on a request whose mode has none, and to IDLE when no request is present. Banks, pipeline registers and the state machine return to zero or IDLE on reset.

Top module: `xret_unit`

## Requirements
- R1: There are exactly five banks, addressed by mode codes 10011 (supervisor), 11011 (undefined), 10111 (abort), 10010 (IRQ) and 10001 (FIQ). A save with `sv_en` high writes `sv_word` into the bank of `sv_mode`. A save whose mode is any other code changes no bank.
- R2: A return request from a banked mode sets `rt_valid` high for exactly the next cycle, with `rt_word` equal to the bank of `cur_mode` as it stood before that clock edge.
- R3: For return kinds 0 (software call) and 1 (undefined instruction), `rt_pc` equals `link`.
- R4: For return kinds 2 (IRQ), 3 (FIQ) and 4 (prefetch abort), `rt_pc` equals `link` minus 4, modulo 2^AW.
- R5: For kind 5 (data abort, retry access), `rt_pc` equals `link` minus 8. For kind 6 (data abort, skip access), it equals `link` minus 4. Both wrap modulo 2^AW.
- R6: For kind 7 (reset context), no bank is read. `rt_word` equals `cur_word` with bits 4:0 replaced by 10000, and `rt_pc` equals `link`.
- R7: When a save and a return address the same bank in the same cycle, the return delivers the old contents. The following return delivers the new word.
- R8: A return request whose `cur_mode` has no bank sets `rt_err` high for exactly the next cycle with `rt_valid` low. This covers user 10000, system 11111 and every unlisted code, and applies whatever the kind. In that cycle `rt_word` equals `cur_word` and `rt_pc` equals `link`.
- R9: After reset all banks hold zero, and `rt_valid`, `rt_err`, `rt_word` and `rt_pc` are zero.
- R10: `rt_valid` and `rt_err` are never high together. Both are low in every cycle that follows a cycle without a return request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sv_en | input | 1 | Save strobe at exception entry |
| sv_mode | input | 5 | Mode code whose bank receives the save |
| sv_word | input | SW | Status word to save |
| rt_req | input | 1 | Return request |
| rt_kind | input | 3 | Return kind code 0..7 |
| cur_mode | input | 5 | Mode in which the return is issued |
| cur_word | input | SW | Current status word |
| link | input | AW | Current link register value |
| rt_valid | output | 1 | Restored outputs are valid this cycle |
| rt_err | output | 1 | Return refused this cycle |
| rt_word | output | SW | Restored status word |
| rt_pc | output | AW | Restored program counter |

## Verification
The bench builds the unit with SW=16 and AW=32. The 16-bit status word leaves an eight-bit opaque field above the I bit, so the reset-context path visibly carries those bits through while replacing the mode field. Every one of the 32 mode codes can then be walked against the bench's own model of the banks. The 32-bit link port lets the link values 0 and 4 drive the minus-8 and minus-4 offsets through the wrap to the top of the address space.

// File: rtl/xret_pkg.sv
package xret_pkg;

    localparam int MODE_W = 5;
    localparam int NBANK  = 5;

    localparam logic [MODE_W-1:0] CODE_USER = 5'b10000;
    localparam logic [MODE_W-1:0] CODE_SYS  = 5'b11111;

    // Bank order: supervisor, undefined, abort, IRQ, FIQ
    localparam logic [MODE_W-1:0] BANK_CODE [NBANK] = '{
        5'b10011, 5'b11011, 5'b10111, 5'b10010, 5'b10001
    };

    typedef enum logic [2:0] {
        RK_SVC_CALL   = 3'd0,
        RK_UNDEF      = 3'd1,
        RK_IRQ        = 3'd2,
        RK_FIQ        = 3'd3,
        RK_PFETCH     = 3'd4,
        RK_DATA_RETRY = 3'd5,
        RK_DATA_SKIP  = 3'd6,
        RK_BOOT       = 3'd7
    } ret_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESTORE = 2'd1,
        ST_REFUSE  = 2'd2
    } ret_state_e;

    function automatic logic has_bank(input logic [MODE_W-1:0] m);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NBANK; i++) begin
            if (m == BANK_CODE[i]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/xret_bank.sv
module xret_bank
    import xret_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [SW-1:0]     wr_word,
    input  logic [MODE_W-1:0] rd_mode,
    output logic [SW-1:0]     rd_word,
    output logic              rd_hit
);

    logic [NBANK-1:0]         wsel;
    logic [NBANK-1:0]         rsel;
    logic [NBANK-1:0][SW-1:0] slot_q;

    // One decoder pair per bank
    for (genvar g = 0; g < NBANK; g++) begin : g_dec
        assign wsel[g] = wr_en && (wr_mode == BANK_CODE[g]);
        assign rsel[g] = (rd_mode == BANK_CODE[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            for (int i = 0; i < NBANK; i++) begin
                if (wsel[i]) slot_q[i] <= wr_word;
            end
        end
    end

    // Read is taken before the edge, so a same-cycle write is not seen
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (rsel[i]) rd_word = rd_word | slot_q[i];
        end
    end

    assign rd_hit = |rsel;

endmodule

// File: rtl/xret_pc_calc.sv
module xret_pc_calc
    import xret_pkg::*;
#(
    parameter int AW = 32
) (
    input  ret_kind_e     kind,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] OFS_ONE = AW'(4);
    localparam logic [AW-1:0] OFS_TWO = AW'(8);

    always_comb begin
        pc = link;
        unique case (kind)
            RK_SVC_CALL, RK_UNDEF, RK_BOOT:         pc = link;
            RK_IRQ, RK_FIQ, RK_PFETCH, RK_DATA_SKIP: pc = link - OFS_ONE;
            RK_DATA_RETRY:                           pc = link - OFS_TWO;
            default:                                 pc = link;
        endcase
    end

endmodule

// File: rtl/xret_ctrl.sv
module xret_ctrl
    import xret_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic hit,
    output logic valid,
    output logic err
);

    ret_state_e state_q;
    ret_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (req) state_d = hit ? ST_RESTORE : ST_REFUSE;
            end
            ST_RESTORE, ST_REFUSE: begin
                if (req) state_d = hit ? ST_RESTORE : ST_REFUSE;
                else     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        valid = 1'b0;
        err   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RESTORE: valid = 1'b1;
            ST_REFUSE:  err   = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/xret_unit.sv
module xret_unit
    import xret_pkg::*;
#(
    parameter int SW = 32,
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sv_en,
    input  logic [MODE_W-1:0] sv_mode,
    input  logic [SW-1:0]     sv_word,
    input  logic              rt_req,
    input  logic [2:0]        rt_kind,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [SW-1:0]     cur_word,
    input  logic [AW-1:0]     link,
    output logic              rt_valid,
    output logic              rt_err,
    output logic [SW-1:0]     rt_word,
    output logic [AW-1:0]     rt_pc
);

    ret_kind_e     kind;
    logic [SW-1:0] bank_word;
    logic          bank_hit;
    logic [AW-1:0] pc_calc;
    logic [SW-1:0] word_q;
    logic [AW-1:0] pc_q;

    assign kind = ret_kind_e'(rt_kind);

    xret_bank #(.SW(SW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sv_en),
        .wr_mode (sv_mode),
        .wr_word (sv_word),
        .rd_mode (cur_mode),
        .rd_word (bank_word),
        .rd_hit  (bank_hit)
    );

    xret_pc_calc #(.AW(AW)) u_pc (
        .kind (kind),
        .link (link),
        .pc   (pc_calc)
    );

    xret_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rt_req),
        .hit   (bank_hit),
        .valid (rt_valid),
        .err   (rt_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            pc_q   <= '0;
        end else if (rt_req) begin
            if (!bank_hit) begin
                word_q <= cur_word;
                pc_q   <= link;
            end else begin
                word_q <= (kind == RK_BOOT) ? {cur_word[SW-1:MODE_W], CODE_USER} : bank_word;
                pc_q   <= pc_calc;
            end
        end
    end

    assign rt_word = word_q;
    assign rt_pc   = pc_q;

endmodule

// File: rtl/xret_checks.sv
module xret_checks
    import xret_pkg::*;
#(
    parameter int SW = 32,
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rt_req,
    input logic [2:0]        rt_kind,
    input logic [MODE_W-1:0] cur_mode,
    input logic [SW-1:0]     cur_word,
    input logic [AW-1:0]     link,
    input logic              rt_valid,
    input logic              rt_err,
    input logic [SW-1:0]     rt_word,
    input logic [AW-1:0]     rt_pc
);

    logic go;
    assign go = rt_req && has_bank(cur_mode);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rt_valid && rt_err));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_req |=> (!rt_valid && !rt_err));

    p_restore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (rt_valid && !rt_err));

    p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req && !has_bank(cur_mode)) |=>
            (rt_err && !rt_valid && rt_word == $past(cur_word) && rt_pc == $past(link)));

    p_pc_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (rt_kind == 3'd0 || rt_kind == 3'd1)) |=> (rt_pc == $past(link)));

    p_pc_minus4_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (rt_kind == 3'd2 || rt_kind == 3'd3 || rt_kind == 3'd4)) |=>
            (rt_pc == $past(link) - AW'(4)));

    p_pc_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && rt_kind == 3'd5) |=> (rt_pc == $past(link) - AW'(8)));

    p_pc_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && rt_kind == 3'd6) |=> (rt_pc == $past(link) - AW'(4)));

    p_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && rt_kind == 3'd7) |=>
            (rt_word[MODE_W-1:0] == 5'b10000 &&
             rt_word[SW-1:MODE_W] == $past(cur_word[SW-1:MODE_W]) &&
             rt_pc == $past(link)));

endmodule

bind xret_unit xret_checks #(.SW(SW), .AW(AW)) u_checks (.*);

// File: tb/xret_unit_bench.sv
module xret_unit_bench;

    localparam int SW = 16;
    localparam int AW = 32;

    typedef struct {
        logic          err;
        logic [SW-1:0] word;
        logic [AW-1:0] pc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sv_en = 1'b0;
    logic [4:0]    sv_mode = '0;
    logic [SW-1:0] sv_word = '0;
    logic          rt_req = 1'b0;
    logic [2:0]    rt_kind = '0;
    logic [4:0]    cur_mode = '0;
    logic [SW-1:0] cur_word = '0;
    logic [AW-1:0] link = '0;
    logic          rt_valid, rt_err;
    logic [SW-1:0] rt_word;
    logic [AW-1:0] rt_pc;

    int checks = 0;
    int failures = 0;
    exp_t sbq[$];
    logic [SW-1:0] mdl [32];
    logic [4:0] banks [5] = '{5'b10011, 5'b11011, 5'b10111, 5'b10010, 5'b10001};

    always #4 clk = ~clk;

    xret_unit #(.SW(SW), .AW(AW)) u_xret_unit (.*);

    function automatic logic banked(input logic [4:0] m);
        return (m == 5'b10011) || (m == 5'b11011) || (m == 5'b10111) ||
               (m == 5'b10010) || (m == 5'b10001);
    endfunction

    function automatic string tag_for(input logic [4:0] m, input logic [2:0] k);
        if (!banked(m)) return "R8";
        if (k <= 3'd1)  return "R3";
        if (k <= 3'd4)  return "R4";
        if (k <= 3'd6)  return "R5";
        return "R6";
    endfunction

    task automatic do_op(input logic s_en, input logic [4:0] s_mode, input logic [SW-1:0] s_word,
                         input logic r_en, input logic [4:0] r_mode, input logic [2:0] k,
                         input logic [AW-1:0] lnk, input logic [SW-1:0] cw, input string tag);
        exp_t e;
        @(negedge clk);
        sv_en = s_en; sv_mode = s_mode; sv_word = s_word;
        rt_req = r_en; cur_mode = r_mode; rt_kind = k; link = lnk; cur_word = cw;
        if (r_en) begin
            e.tag = tag;
            if (!banked(r_mode)) begin
                e.err = 1'b1; e.word = cw; e.pc = lnk;
            end else begin
                e.err = 1'b0;
                e.word = (k == 3'd7) ? {cw[SW-1:5], 5'b10000} : mdl[r_mode];
                case (k)
                    3'd0, 3'd1, 3'd7: e.pc = lnk;
                    3'd5:             e.pc = lnk - 32'd8;
                    default:          e.pc = lnk - 32'd4;
                endcase
            end
            sbq.push_back(e);
        end
        if (s_en && banked(s_mode)) mdl[s_mode] = s_word;
        @(posedge clk);
        #1;
        sv_en = 1'b0; rt_req = 1'b0;
    endtask

    // Monitor: compares results against the scoreboard queue
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (rt_valid || rt_err) begin
                checks++;
                if (sbq.size() == 0) begin
                    failures++;
                    $display("FAIL R10 spurious strobe valid=%b err=%b expected none", rt_valid, rt_err);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (rt_err !== e.err || rt_valid !== !e.err || rt_word !== e.word || rt_pc !== e.pc) begin
                        failures++;
                        $display("FAIL %s err=%b/%b valid=%b word act=%h exp=%h pc act=%h exp=%h",
                                 e.tag, rt_err, e.err, rt_valid, rt_word, e.word, rt_pc, e.pc);
                    end
                end
            end else if (sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                failures++;
                $display("FAIL %s R10 no strobe act valid=%b err=%b expected err=%b",
                         e.tag, rt_valid, rt_err, e.err);
            end
        end
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL R10 watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rt_valid !== 1'b0 || rt_err !== 1'b0 || rt_word !== '0 || rt_pc !== '0) begin
            failures++;
            $display("FAIL R9 reset outputs act=%b%b %h %h exp=00 0000 00000000",
                     rt_valid, rt_err, rt_word, rt_pc);
        end
        rst_n = 1'b1;

        // R9 / R2 / R8: every mode code after reset
        for (int m = 0; m < 32; m++)
            do_op(1'b0, 5'd0, '0, 1'b1, 5'(m), 3'd0, 32'h100 + 32'(m * 4),
                  16'hA500 | 16'(m), banked(5'(m)) ? "R9" : "R8");

        // R1: fill each bank, then every kind from every bank
        for (int b = 0; b < 5; b++)
            do_op(1'b1, banks[b], 16'h1234 ^ 16'(b * 16'h1111), 1'b0, 5'd0, 3'd0, '0, '0, "R1");
        for (int b = 0; b < 5; b++)
            for (int k = 0; k < 8; k++)
                do_op(1'b0, 5'd0, '0, 1'b1, banks[b], 3'(k), 32'h8000_0040 + 32'(b * 256 + k * 16),
                      16'hC3E0 | 16'(k), tag_for(banks[b], 3'(k)));

        // R5: wrap at the bottom of the address space
        do_op(1'b0, 5'd0, '0, 1'b1, 5'b10111, 3'd5, 32'h0, 16'h0, "R5");
        do_op(1'b0, 5'd0, '0, 1'b1, 5'b10111, 3'd6, 32'h0, 16'h0, "R5");
        do_op(1'b0, 5'd0, '0, 1'b1, 5'b10010, 3'd5, 32'h4, 16'h0, "R5");

        // R7: same-cycle save and return to the IRQ bank
        do_op(1'b1, 5'b10010, 16'h5AA5, 1'b1, 5'b10010, 3'd2, 32'h200, 16'h0, "R7");
        do_op(1'b0, 5'd0, '0, 1'b1, 5'b10010, 3'd2, 32'h200, 16'h0, "R7");

        // R1: saves to modes without a bank change nothing
        do_op(1'b1, 5'b10000, 16'hBEEF, 1'b0, 5'd0, 3'd0, '0, '0, "R1");
        do_op(1'b1, 5'b11111, 16'hDEAD, 1'b0, 5'd0, 3'd0, '0, '0, "R1");
        do_op(1'b1, 5'b00000, 16'hFACE, 1'b0, 5'd0, 3'd0, '0, '0, "R1");
        for (int b = 0; b < 5; b++)
            do_op(1'b0, 5'd0, '0, 1'b1, banks[b], 3'd1, 32'h300, 16'h0, "R1");

        // R8: reset-context kind from user and system modes is refused
        do_op(1'b0, 5'd0, '0, 1'b1, 5'b10000, 3'd7, 32'h400, 16'h7F1F, "R8");
        do_op(1'b0, 5'd0, '0, 1'b1, 5'b11111, 3'd4, 32'h404, 16'h0E5F, "R8");

        // R10: idle cycles stay quiet
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (rt_valid !== 1'b0 || rt_err !== 1'b0) begin
                failures++;
                $display("FAIL R10 idle act=%b%b exp=00", rt_valid, rt_err);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule